// File: doc/BRIEF.md
# Scalar-to-Vector Instruction Expander

This block sits right after instruction decode. It takes one decoded three-operand integer instruction and turns it into a series of element operations, which it pushes into a downstream issue FIFO. Each operand field is looked up in a redirection table with 16 slots. If a slot is marked vector, the operand's register index is replaced by that slot's start register, and the index steps by one per element. If the operand has no slot, or its slot is not marked vector, the operand stays on the same register for every element.

A second table with 16 slots links a destination register to the integer register that holds its predicate mask. The block reads that mask through a read port when it accepts an instruction. Element `i` is issued only if bit `i` of the mask is set. Elements that are masked off take no FIFO slot.

Before any element is issued, the block checks for illegal vector use. It flags the error and drops the instruction. While the FIFO is full the block waits, and it takes no new instruction until the last element of the current one has gone out.

Top module: `vexp_top`

## Requirements
- R1: For an operand whose redirection entry is marked vector, element `i` uses register `start + i`. An operand with no entry, or with an entry not marked vector, uses its own index for every element.
- R2: An instruction with at least one vector operand yields element numbers 0 to VL-1 in ascending order. Each element is carried in `out_elem_o` together with the opcode and the three resolved indices.
- R3: Element `i` is issued only if bit `i` of the mask is set. The mask is the value on `mask_data_i` at the accepting clock edge, read from the register named by the predicate entry keyed on the original `rd`. Elements that are masked off produce no FIFO push.
- R4: If no predicate entry matches `rd`, the mask is all ones.
- R5: An instruction whose three operands are all scalar issues exactly once, with element number 0, whatever VL is. That single issue is gated by mask bit 0.
- R6: Each table has 16 slots, written by slot index with a key, a valid bit and a value. A lookup takes the lowest-numbered valid slot whose key matches. Writing a slot with the valid bit low removes its mapping.
- R7: If a vector operand would step past register 31 (start + VL > 32), the block raises cause 1 and issues nothing.
- R8: An instruction with opcode `1100111` and any vector operand raises cause 2 and issues nothing. The same opcode with all scalar operands passes through normally.
- R9: If `rd` is vector and its entry length is less than VL, the block raises cause 3 and issues nothing. When several causes apply, cause 2 wins over cause 3, and cause 3 wins over cause 1.
- R10: While `out_ready_i` is low and `out_valid_o` is high, every output field holds its value, and no element is lost or duplicated.
- R11: After reset, `in_ready_o` is 1, `out_valid_o` is 0 and `exc_valid_o` is 0. `in_ready_o` is low from the cycle after an expansion starts, and returns high in the cycle after the last element leaves. `exc_valid_o` pulses for one cycle after the accepting edge, and `exc_cause_o` holds the cause at that time.
- R12: An instruction with a vector operand and VL = 0 issues nothing and raises nothing. The block is ready again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rt_we_i | input | 1 | Redirection table write strobe |
| rt_idx_i | input | 4 | Redirection slot to write |
| rt_valid_i | input | 1 | Slot valid bit to write |
| rt_key_i | input | 5 | Architectural register key |
| rt_vec_i | input | 1 | Vector flag |
| rt_base_i | input | 5 | Start register index |
| rt_len_i | input | 6 | Vector length of the register |
| pt_we_i | input | 1 | Predicate table write strobe |
| pt_idx_i | input | 4 | Predicate slot to write |
| pt_valid_i | input | 1 | Slot valid bit to write |
| pt_key_i | input | 5 | Destination register key |
| pt_reg_i | input | 5 | Register holding the mask |
| vl_i | input | 6 | Current vector length |
| in_valid_i | input | 1 | Decoded instruction valid |
| in_ready_o | output | 1 | Expander can take an instruction |
| in_op_i | input | 7 | Opcode |
| in_rd_i | input | 5 | Destination register |
| in_rs1_i | input | 5 | First source register |
| in_rs2_i | input | 5 | Second source register |
| mask_addr_o | output | 5 | Register file read address for the mask |
| mask_data_i | input | 32 | Mask value read back |
| out_valid_o | output | 1 | Element operation valid toward FIFO |
| out_ready_i | input | 1 | FIFO not full |
| out_op_o | output | 7 | Element opcode |
| out_rd_o | output | 5 | Resolved destination |
| out_rs1_o | output | 5 | Resolved first source |
| out_rs2_o | output | 5 | Resolved second source |
| out_elem_o | output | 5 | Element number |
| exc_valid_o | output | 1 | Exception pulse |
| exc_cause_o | output | 2 | 1 range, 2 jump-register, 3 short destination |

## Verification
The bench probes the range edge where start + VL equals 32 exactly, and the case one beyond it. A design that wraps or checks off by one would issue x0 or refuse a legal run. It combines the error causes to test their priority, and it shadows one key in two slots, so a design that picks the wrong slot would show the wrong start register. Random FIFO back-pressure together with a sparse mask shows whether masked elements are dropped without wasting a cycle, and whether held elements stay stable rather than advancing or repeating. VL = 0 and the all-scalar case with mask bit 0 clear catch a design that issues a stray element.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_RANGE = 2'd1,
    EXC_JALR  = 2'd2,
    EXC_SHORT = 2'd3
  } exc_cause_e;
endpackage

// File: rtl/vexp_kv_table.sv
module vexp_kv_table #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 5,
  parameter int VAL_W   = 8,
  parameter int NLOOK   = 1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic                            wr_valid_i,
  input  logic [KEY_W-1:0]                wr_key_i,
  input  logic [VAL_W-1:0]                wr_val_i,
  input  logic [NLOOK-1:0][KEY_W-1:0]     look_key_i,
  output logic [NLOOK-1:0]                hit_o,
  output logic [NLOOK-1:0][VAL_W-1:0]     val_o
);
  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][KEY_W-1:0] key_q;
  logic [ENTRIES-1:0][VAL_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      key_q <= '0;
      val_q <= '0;
    end else if (we_i) begin
      vld_q[wr_idx_i] <= wr_valid_i;
      key_q[wr_idx_i] <= wr_key_i;
      val_q[wr_idx_i] <= wr_val_i;
    end
  end

  // lowest matching slot wins
  for (genvar g = 0; g < NLOOK; g++) begin : g_look
    logic             hit;
    logic [VAL_W-1:0] val;
    always_comb begin
      hit = 1'b0;
      val = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (vld_q[e] && key_q[e] == look_key_i[g]) begin
          hit = 1'b1;
          val = val_q[e];
        end
      end
    end
    assign hit_o[g] = hit;
    assign val_o[g] = val;
  end
endmodule

// File: rtl/vexp_seq.sv
module vexp_seq #(
  parameter int REG_W  = 5,
  parameter int XLEN   = 32,
  parameter int OP_W   = 7,
  localparam int ELEM_W = $clog2(XLEN)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  scalar_only_i,
  input  logic [ELEM_W-1:0]     last_i,
  input  logic [XLEN-1:0]       mask_i,
  input  logic [OP_W-1:0]       op_i,
  input  logic [2:0][REG_W-1:0] base_i,
  input  logic [2:0]            vec_i,
  output logic                  busy_o,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [OP_W-1:0]       out_op_o,
  output logic [REG_W-1:0]      out_rd_o,
  output logic [REG_W-1:0]      out_rs1_o,
  output logic [REG_W-1:0]      out_rs2_o,
  output logic [ELEM_W-1:0]     out_elem_o
);
  logic                  busy_q;
  logic [ELEM_W-1:0]     elem_q, last_q;
  logic [XLEN-1:0]       mask_q;
  logic [OP_W-1:0]       op_q;
  logic [2:0][REG_W-1:0] base_q;
  logic [2:0]            vec_q;
  logic                  cur_en, advance, at_last;
  logic [2:0][REG_W-1:0] reg_cur;

  assign cur_en  = mask_q[elem_q];
  assign advance = busy_q && (!cur_en || out_ready_i);
  assign at_last = elem_q == last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      elem_q <= '0;
      last_q <= '0;
      mask_q <= '0;
      op_q   <= '0;
      base_q <= '0;
      vec_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      elem_q <= '0;
      last_q <= scalar_only_i ? '0 : last_i;
      mask_q <= mask_i;
      op_q   <= op_i;
      base_q <= base_i;
      vec_q  <= vec_i;
    end else if (advance) begin
      if (at_last) busy_q <= 1'b0;
      else         elem_q <= elem_q + 1'b1;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_opnd
    assign reg_cur[g] = vec_q[g] ? base_q[g] + REG_W'(elem_q) : base_q[g];
  end

  assign busy_o      = busy_q;
  assign out_valid_o = busy_q && cur_en;
  assign out_op_o    = op_q;
  assign out_rd_o    = reg_cur[0];
  assign out_rs1_o   = reg_cur[1];
  assign out_rs2_o   = reg_cur[2];
  assign out_elem_o  = elem_q;

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_elem_o) &&
      $stable(out_rd_o) && $stable(out_rs1_o) && $stable(out_rs2_o) && $stable(out_op_o));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && advance && !at_last |=> busy_o && out_elem_o == $past(out_elem_o) + 1'b1);

  a_r5_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && vec_q == 3'b000 |-> out_elem_o == '0);
endmodule

// File: rtl/vexp_top.sv
module vexp_top import vexp_pkg::*; #(
  parameter int NREG        = 32,
  parameter int XLEN        = 32,
  parameter int OP_W        = 7,
  parameter int TBL_ENTRIES = 16,
  parameter logic [OP_W-1:0] JALR_OP = 7'b1100111,
  localparam int REG_W  = $clog2(NREG),
  localparam int VL_W   = $clog2(XLEN + 1),
  localparam int ELEM_W = $clog2(XLEN),
  localparam int TIDX_W = $clog2(TBL_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rt_we_i,
  input  logic [TIDX_W-1:0] rt_idx_i,
  input  logic              rt_valid_i,
  input  logic [REG_W-1:0]  rt_key_i,
  input  logic              rt_vec_i,
  input  logic [REG_W-1:0]  rt_base_i,
  input  logic [VL_W-1:0]   rt_len_i,
  input  logic              pt_we_i,
  input  logic [TIDX_W-1:0] pt_idx_i,
  input  logic              pt_valid_i,
  input  logic [REG_W-1:0]  pt_key_i,
  input  logic [REG_W-1:0]  pt_reg_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OP_W-1:0]   in_op_i,
  input  logic [REG_W-1:0]  in_rd_i,
  input  logic [REG_W-1:0]  in_rs1_i,
  input  logic [REG_W-1:0]  in_rs2_i,
  output logic [REG_W-1:0]  mask_addr_o,
  input  logic [XLEN-1:0]   mask_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OP_W-1:0]   out_op_o,
  output logic [REG_W-1:0]  out_rd_o,
  output logic [REG_W-1:0]  out_rs1_o,
  output logic [REG_W-1:0]  out_rs2_o,
  output logic [ELEM_W-1:0] out_elem_o,
  output logic              exc_valid_o,
  output logic [1:0]        exc_cause_o
);
  localparam int RV_W  = 1 + REG_W + VL_W;
  localparam int SUM_W = VL_W + REG_W + 1;

  logic [2:0][REG_W-1:0] look_key;
  logic [2:0]            rhit;
  logic [2:0][RV_W-1:0]  rval;
  logic [2:0]            opv, over;
  logic [2:0][REG_W-1:0] opbase;
  logic [2:0][VL_W-1:0]  oplen;
  logic [0:0]            phit;
  logic [0:0][REG_W-1:0] pval;
  logic                  any_vec, accept, start, busy;
  logic                  vl_zero;
  logic [XLEN-1:0]       mask;
  logic [VL_W-1:0]       vl_m1;
  exc_cause_e            cause;
  logic                  exc_valid_q;
  exc_cause_e            exc_cause_q;
  logic                  unused_len;

  assign look_key = {in_rs2_i, in_rs1_i, in_rd_i};

  vexp_kv_table #(
    .ENTRIES(TBL_ENTRIES), .KEY_W(REG_W), .VAL_W(RV_W), .NLOOK(3)
  ) u_redir (
    .clk_i, .rst_ni,
    .we_i(rt_we_i), .wr_idx_i(rt_idx_i), .wr_valid_i(rt_valid_i),
    .wr_key_i(rt_key_i), .wr_val_i({rt_vec_i, rt_base_i, rt_len_i}),
    .look_key_i(look_key), .hit_o(rhit), .val_o(rval)
  );

  vexp_kv_table #(
    .ENTRIES(TBL_ENTRIES), .KEY_W(REG_W), .VAL_W(REG_W), .NLOOK(1)
  ) u_pred (
    .clk_i, .rst_ni,
    .we_i(pt_we_i), .wr_idx_i(pt_idx_i), .wr_valid_i(pt_valid_i),
    .wr_key_i(pt_key_i), .wr_val_i(pt_reg_i),
    .look_key_i(in_rd_i), .hit_o(phit), .val_o(pval)
  );

  assign vl_zero = vl_i == '0;

  for (genvar g = 0; g < 3; g++) begin : g_res
    logic [SUM_W-1:0] reach;
    assign opv[g]    = rhit[g] && rval[g][RV_W-1];
    assign opbase[g] = opv[g] ? rval[g][RV_W-2 -: REG_W] : look_key[g];
    assign oplen[g]  = rval[g][VL_W-1:0];
    assign reach     = SUM_W'(opbase[g]) + SUM_W'(vl_i);
    assign over[g]   = opv[g] && !vl_zero && reach > SUM_W'(NREG);
  end
  assign unused_len = ^{oplen[1], oplen[2]};

  assign any_vec = |opv;

  always_comb begin
    cause = EXC_NONE;
    if (|over)                                      cause = EXC_RANGE;
    if (opv[0] && oplen[0] < vl_i)                  cause = EXC_SHORT;
    if (in_op_i == JALR_OP && any_vec)              cause = EXC_JALR;
  end

  assign mask_addr_o = phit[0] ? pval[0] : '0;
  assign mask        = phit[0] ? mask_data_i : '1;

  assign in_ready_o = !busy;
  assign accept     = in_valid_i && in_ready_o;
  assign start      = accept && cause == EXC_NONE && (!any_vec || !vl_zero);
  assign vl_m1      = vl_i - VL_W'(1);

  vexp_seq #(.REG_W(REG_W), .XLEN(XLEN), .OP_W(OP_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .scalar_only_i(!any_vec), .last_i(ELEM_W'(vl_m1)),
    .mask_i(mask), .op_i(in_op_i), .base_i(opbase), .vec_i(opv),
    .busy_o(busy), .out_valid_o, .out_ready_i,
    .out_op_o, .out_rd_o, .out_rs1_o, .out_rs2_o, .out_elem_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_valid_q <= 1'b0;
      exc_cause_q <= EXC_NONE;
    end else begin
      exc_valid_q <= accept && cause != EXC_NONE;
      if (accept) exc_cause_q <= cause;
    end
  end
  assign exc_valid_o = exc_valid_q;
  assign exc_cause_o = exc_cause_q;

  a_r11_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r7_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> !out_valid_o && in_ready_o);

  a_r11_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |=> !exc_valid_o || $past(accept));
endmodule

// File: tb/tb_vexp_top.sv
module tb_vexp_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] OP_ADD  = 7'b0110011;
  localparam logic [6:0] OP_JALR = 7'b1100111;

  typedef struct {
    logic [6:0] op;
    logic [4:0] rd, rs1, rs2, elem;
    string      tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rt_we = 0, rt_valid = 0, rt_vec = 0;
  logic [3:0] rt_idx = 0;
  logic [4:0] rt_key = 0, rt_base = 0;
  logic [5:0] rt_len = 0;
  logic pt_we = 0, pt_valid = 0;
  logic [3:0] pt_idx = 0;
  logic [4:0] pt_key = 0, pt_reg = 0;
  logic [5:0] vl = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [6:0] in_op = 0;
  logic [4:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0;
  logic [4:0] mask_addr;
  logic [31:0] mask_data;
  logic out_valid, out_ready = 1;
  logic [6:0] out_op;
  logic [4:0] out_rd, out_rs1, out_rs2, out_elem;
  logic exc_valid;
  logic [1:0] exc_cause;

  logic [31:0] regfile_m [32];
  assign mask_data = regfile_m[mask_addr];

  vexp_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rt_we_i(rt_we), .rt_idx_i(rt_idx), .rt_valid_i(rt_valid), .rt_key_i(rt_key),
    .rt_vec_i(rt_vec), .rt_base_i(rt_base), .rt_len_i(rt_len),
    .pt_we_i(pt_we), .pt_idx_i(pt_idx), .pt_valid_i(pt_valid), .pt_key_i(pt_key),
    .pt_reg_i(pt_reg), .vl_i(vl),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_op_i(in_op),
    .in_rd_i(in_rd), .in_rs1_i(in_rs1), .in_rs2_i(in_rs2),
    .mask_addr_o(mask_addr), .mask_data_i(mask_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_op_o(out_op),
    .out_rd_o(out_rd), .out_rs1_o(out_rs1), .out_rs2_o(out_rs2), .out_elem_o(out_elem),
    .exc_valid_o(exc_valid), .exc_cause_o(exc_cause)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  item_t exp_q[$];

  // table shadows (requirement model)
  bit       m_rv[16], m_rvec[16];
  bit [4:0] m_rkey[16], m_rbase[16];
  bit [5:0] m_rlen[16];
  bit       m_pv[16];
  bit [4:0] m_pkey[16], m_preg[16];

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // stall generator for R10
  bit stall_mode = 0;
  logic [7:0] lfsr = 8'hA7;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  // monitor: scoreboard compare and R10 hold check
  bit       prev_stall = 0;
  logic [4:0] prev_rd, prev_rs1, prev_elem;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_rd == prev_rd && out_rs1 == prev_rs1 && out_elem == prev_elem,
              "R10", "held element", int'(out_elem), int'(prev_elem));
      end
      prev_stall = out_valid && !out_ready;
      prev_rd = out_rd; prev_rs1 = out_rs1; prev_elem = out_elem;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", "unexpected element", int'(out_elem), -1);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(out_elem == e.elem, e.tag, "elem", int'(out_elem), int'(e.elem));
          check(out_rd == e.rd && out_rs1 == e.rs1 && out_rs2 == e.rs2 && out_op == e.op,
                e.tag, "rd/rs1/rs2 packed",
                int'({out_rd, out_rs1, out_rs2}), int'({e.rd, e.rs1, e.rs2}));
        end
      end
    end
  end

  task automatic wr_rt(int slot, bit v, int key, bit vec, int base, int len);
    @(negedge clk);
    rt_we = 1; rt_idx = 4'(slot); rt_valid = v; rt_key = 5'(key);
    rt_vec = vec; rt_base = 5'(base); rt_len = 6'(len);
    @(posedge clk); #1 rt_we = 0;
    m_rv[slot] = v; m_rkey[slot] = 5'(key); m_rvec[slot] = vec;
    m_rbase[slot] = 5'(base); m_rlen[slot] = 6'(len);
  endtask

  task automatic wr_pt(int slot, bit v, int key, int rg);
    @(negedge clk);
    pt_we = 1; pt_idx = 4'(slot); pt_valid = v; pt_key = 5'(key); pt_reg = 5'(rg);
    @(posedge clk); #1 pt_we = 0;
    m_pv[slot] = v; m_pkey[slot] = 5'(key); m_preg[slot] = 5'(rg);
  endtask

  task automatic resolve(logic [4:0] r, output bit vec, output logic [4:0] base);
    vec = 0; base = r;
    for (int s = 0; s < 16; s++)
      if (m_rv[s] && m_rkey[s] == r) begin vec = m_rvec[s]; if (vec) base = m_rbase[s]; break; end
  endtask

  // exp_cause derived by hand from R7/R8/R9
  task automatic run(logic [6:0] op, int rd, int rs1, int rs2, int vlen, int exp_cause, string tag);
    bit v0, v1, v2, started;
    logic [4:0] b0, b1, b2;
    logic [31:0] m;
    int n;
    resolve(5'(rd), v0, b0); resolve(5'(rs1), v1, b1); resolve(5'(rs2), v2, b2);
    m = '1;
    for (int s = 0; s < 16; s++)
      if (m_pv[s] && m_pkey[s] == 5'(rd)) begin m = regfile_m[m_preg[s]]; break; end
    n = (v0 || v1 || v2) ? vlen : 1;
    started = exp_cause == 0 && n > 0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    if (exp_cause == 0)
      for (int i = 0; i < n; i++)
        if (m[i]) begin
          item_t it;
          it.op = op; it.elem = 5'(i); it.tag = tag;
          it.rd  = v0 ? b0 + 5'(i) : b0;
          it.rs1 = v1 ? b1 + 5'(i) : b1;
          it.rs2 = v2 ? b2 + 5'(i) : b2;
          exp_q.push_back(it);
        end
    in_valid = 1; in_op = op; in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2); vl = 6'(vlen);
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    check(exc_valid == (exp_cause != 0), tag, "exc_valid", int'(exc_valid), int'(exp_cause != 0));
    if (exp_cause != 0) check(exc_cause == 2'(exp_cause), tag, "exc_cause", int'(exc_cause), exp_cause);
    check(in_ready == !started, "R11", "in_ready after accept", int'(in_ready), int'(!started));
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0 && !out_valid, "R3", "drained", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regfile_m[i] = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1 && out_valid == 0 && exc_valid == 0, "R11", "reset state",
          int'({in_ready, out_valid, exc_valid}), 4);
    rst_n = 1;
    wr_rt(0, 1, 5, 1, 8, 8);
    wr_rt(1, 1, 6, 1, 16, 8);
    // R5, R4: all scalar, no predicate entry
    run(OP_ADD, 3, 4, 7, 4, 0, "R5"); drain();
    // R1, R2: rd and rs1 vector, rs2 scalar
    run(OP_ADD, 5, 6, 7, 4, 0, "R1"); drain();
    // R3: predicate entry on rd=5 -> x10
    regfile_m[10] = 32'b1010;
    wr_pt(0, 1, 5, 10);
    run(OP_ADD, 5, 6, 7, 4, 0, "R3"); drain();
    // R10: back-pressure, sparse mask
    regfile_m[10] = 32'hA5;
    stall_mode = 1;
    run(OP_ADD, 5, 6, 5, 8, 0, "R10"); drain();
    stall_mode = 0;
    // R7: range edge 28+4=32 ok, 28+5 overflows
    wr_rt(2, 1, 9, 1, 28, 8);
    run(OP_ADD, 3, 9, 4, 4, 0, "R7"); drain();
    run(OP_ADD, 3, 9, 4, 5, 1, "R7");
    // R8: jump-register with vector operand, and scalar pass-through
    run(OP_JALR, 3, 6, 0, 2, 2, "R8");
    run(OP_JALR, 3, 4, 0, 2, 0, "R8"); drain();
    // R9: short destination, and priority with jump-register and range
    run(OP_ADD, 5, 6, 7, 9, 3, "R9");
    run(OP_JALR, 5, 6, 7, 9, 2, "R9");
    run(OP_ADD, 5, 9, 7, 9, 3, "R9");
    // R12: vector with VL=0
    run(OP_ADD, 3, 6, 4, 0, 0, "R12"); drain();
    // R6: shadowed key picks slot 1, cleared slot makes rd=5 scalar
    wr_rt(3, 1, 6, 1, 20, 8);
    wr_rt(0, 0, 5, 1, 8, 8);
    regfile_m[10] = 32'b110;
    run(OP_ADD, 5, 6, 7, 3, 0, "R6"); drain();
    // R5: all scalar gated by mask bit 0 clear -> nothing issued
    run(OP_ADD, 5, 4, 7, 3, 0, "R5"); drain();
    regfile_m[10] = 32'b1;
    run(OP_ADD, 5, 4, 7, 3, 0, "R5"); drain();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule